// File: doc/BRIEF.md
# Character Display Timing Generator

This block produces raster timing for a character-mapped display with 80 visible columns and 24 text rows, each row drawn as 10 scan lines. Every clock is one character clock. A column counter runs through the visible columns and then a horizontal blanking interval. When it reaches the first blanking column, it sends a one-cycle pulse that steps a scan-line counter. That counter carries into a character-row counter. The row counter runs on past the last text row through a few blanking rows before the frame starts again.

Two drive outputs are produced. Horizontal drive is a registered pulse decoded from the column count. Vertical drive starts when the scan line that ends text row 23 has finished, and it lasts a fixed number of scan lines. A display-enable output marks the visible area. The counters are brought out so that they can address display RAM and the character generator. A 2:1 multiplexer forms the RAM word address either from the raster position or from a cursor position supplied by the processor. No data stream crosses the block's edge, so every pin is a plain level and there is no handshake.

Top module: `chardisp_timing`

## Requirements
- R1: While rst_n is low, col, scan and row are 0, and hdrive and vdrive are 0.
- R2: col increases by one on every clock. It wraps from COLS+HBLANK-1 (99 by default) to 0.
- R3: On each clock edge where col equals COLS (80), scan increases by one. When scan is SCANS-1 (9) it wraps to 0 instead, and row then increases by one. row wraps to 0 after ROWS+VBLANK_ROWS-1 (25). On all other edges, scan and row hold their values.
- R4: hdrive is a register one character clock behind the column decode. It is 1 exactly in the cycles whose col output lies in HS_START+1 to HS_START+HS_W (85 to 92).
- R5: vdrive becomes 1 at the line-step edge that leaves scan 9 of row 23. It stays 1 for VS_LINES (4) line steps, which is the scan lines where row*SCANS+scan lies in 240 to 243. It is 0 at all other times.
- R6: de is 1 exactly when col < 80 and row < 24.
- R7: With src_sel = 0, addr equals row*COLS+col of the current raster position, truncated to 11 bits. It follows that position in the same cycle.
- R8: With src_sel = 1, addr equals cur_row*COLS+cur_col, combinationally. The raster counters are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 1 | Address source: 0 = raster, 1 = processor cursor |
| cur_col | input | 7 | Cursor column |
| cur_row | input | 5 | Cursor character row |
| col | output | 7 | Current column (0..99) |
| scan | output | 4 | Scan line within the character row (0..9) |
| row | output | 5 | Character row (0..25) |
| hdrive | output | 1 | Horizontal drive |
| vdrive | output | 1 | Vertical drive |
| de | output | 1 | Display enable |
| addr | output | 11 | Display RAM word address |

## Verification
The counters and both drive outputs change one clock edge after the condition that causes them. After N edges since reset release, col is therefore N mod 100, and the line index is the number of earlier edges whose column was 80. The bench derives col, scan, row, hdrive and vdrive from these closed-form counts. It samples them on the falling edge, so every register stage has settled. de and addr are combinational, so the bench compares them on the falling edge of the same cycle in which it changes src_sel or the cursor inputs.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  typedef enum logic {
    SRC_RASTER = 1'b0,
    SRC_CPU    = 1'b1
  } addr_src_e;
endpackage

// File: rtl/chardisp_hcount.sv
module chardisp_hcount #(
  parameter int COLS     = 80,
  parameter int HBLANK   = 20,
  parameter int HS_START = 84,
  parameter int HS_W     = 8,
  localparam int TOTAL   = COLS + HBLANK,
  localparam int CW      = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] col,
  output logic          line_step,
  output logic          hdrive
);
  localparam logic [CW-1:0] LAST  = CW'(TOTAL - 1);
  localparam logic [CW-1:0] STEP  = CW'(COLS);
  localparam logic [CW-1:0] HS_LO = CW'(HS_START);
  localparam logic [CW-1:0] HS_HI = CW'(HS_START + HS_W - 1);

  logic hs_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col <= '0;
    else if (col == LAST) col <= '0;
    else col <= col + 1'b1;
  end

  assign line_step = (col == STEP);
  assign hs_window = (col >= HS_LO) && (col <= HS_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdrive <= 1'b0;
    else hdrive <= hs_window;
  end
endmodule

// File: rtl/chardisp_vcount.sv
module chardisp_vcount #(
  parameter int SCANS       = 10,
  parameter int ROWS        = 24,
  parameter int VBLANK_ROWS = 2,
  parameter int VS_LINES    = 4,
  localparam int VROWS      = ROWS + VBLANK_ROWS,
  localparam int SW         = $clog2(SCANS),
  localparam int RW         = $clog2(VROWS),
  localparam int VW         = $clog2(VS_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_step,
  output logic [SW-1:0] scan,
  output logic [RW-1:0] row,
  output logic          vdrive
);
  localparam logic [SW-1:0] SCAN_LAST = SW'(SCANS - 1);
  localparam logic [RW-1:0] ROW_LAST  = RW'(VROWS - 1);
  localparam logic [RW-1:0] ROW_TEXT  = RW'(ROWS - 1);

  logic [VW-1:0] vs_left;
  logic          frame_text_end;

  assign frame_text_end = line_step && (scan == SCAN_LAST) && (row == ROW_TEXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan <= '0;
      row  <= '0;
    end else if (line_step) begin
      if (scan == SCAN_LAST) begin
        scan <= '0;
        row  <= (row == ROW_LAST) ? '0 : row + 1'b1;
      end else begin
        scan <= scan + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vdrive  <= 1'b0;
      vs_left <= '0;
    end else if (frame_text_end) begin
      vdrive  <= 1'b1;
      vs_left <= VW'(VS_LINES - 1);
    end else if (line_step && vdrive) begin
      if (vs_left == '0) vdrive <= 1'b0;
      else vs_left <= vs_left - 1'b1;
    end
  end
endmodule

// File: rtl/chardisp_addr_mux.sv
module chardisp_addr_mux
  import chardisp_pkg::*;
#(
  parameter int COLS = 80,
  parameter int CW   = 7,
  parameter int RW   = 5,
  parameter int AW   = 11
) (
  input  addr_src_e     src,
  input  logic [CW-1:0] r_col,
  input  logic [RW-1:0] r_row,
  input  logic [CW-1:0] c_col,
  input  logic [RW-1:0] c_row,
  output logic [AW-1:0] addr
);
  logic [CW-1:0] sel_col;
  logic [RW-1:0] sel_row;
  int            lin;

  always_comb begin
    sel_col = (src == SRC_CPU) ? c_col : r_col;
    sel_row = (src == SRC_CPU) ? c_row : r_row;
    lin     = int'(sel_row) * COLS + int'(sel_col);
    addr    = lin[AW-1:0];
  end
endmodule

// File: rtl/chardisp_timing.sv
module chardisp_timing
  import chardisp_pkg::*;
#(
  parameter int COLS        = 80,
  parameter int HBLANK      = 20,
  parameter int HS_START    = 84,
  parameter int HS_W        = 8,
  parameter int SCANS       = 10,
  parameter int ROWS        = 24,
  parameter int VBLANK_ROWS = 2,
  parameter int VS_LINES    = 4,
  localparam int CW         = $clog2(COLS + HBLANK),
  localparam int SW         = $clog2(SCANS),
  localparam int RW         = $clog2(ROWS + VBLANK_ROWS),
  localparam int AW         = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_sel,
  input  logic [CW-1:0] cur_col,
  input  logic [RW-1:0] cur_row,
  output logic [CW-1:0] col,
  output logic [SW-1:0] scan,
  output logic [RW-1:0] row,
  output logic          hdrive,
  output logic          vdrive,
  output logic          de,
  output logic [AW-1:0] addr
);
  logic line_step;

  chardisp_hcount #(
    .COLS(COLS), .HBLANK(HBLANK), .HS_START(HS_START), .HS_W(HS_W)
  ) u_h (
    .clk(clk), .rst_n(rst_n), .col(col), .line_step(line_step), .hdrive(hdrive)
  );

  chardisp_vcount #(
    .SCANS(SCANS), .ROWS(ROWS), .VBLANK_ROWS(VBLANK_ROWS), .VS_LINES(VS_LINES)
  ) u_v (
    .clk(clk), .rst_n(rst_n), .line_step(line_step),
    .scan(scan), .row(row), .vdrive(vdrive)
  );

  assign de = (col < CW'(COLS)) && (row < RW'(ROWS));

  chardisp_addr_mux #(.COLS(COLS), .CW(CW), .RW(RW), .AW(AW)) u_mux (
    .src(addr_src_e'(src_sel)), .r_col(col), .r_row(row),
    .c_col(cur_col), .c_row(cur_row), .addr(addr)
  );
endmodule

// File: rtl/chardisp_timing_chk.sv
module chardisp_timing_chk #(
  parameter int COLS     = 80,
  parameter int TOTAL    = 100,
  parameter int HS_START = 84,
  parameter int SCANS    = 10,
  parameter int ROWS     = 24,
  parameter int CW       = 7,
  parameter int SW       = 4,
  parameter int RW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] col,
  input logic [SW-1:0] scan,
  input logic [RW-1:0] row,
  input logic          hdrive,
  input logic          vdrive
);
  p_col_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) == TOTAL - 1 |=> col == '0);

  p_scan_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(col) == COLS && int'(scan) == SCANS - 1) |=> scan == '0);

  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) != COLS |=> $stable(row) && $stable(scan));

  p_hdrive_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrive) |-> int'($past(col)) == HS_START);

  p_vdrive_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdrive) |-> (int'($past(scan)) == SCANS - 1 && int'($past(row)) == ROWS - 1));
endmodule

bind chardisp_timing chardisp_timing_chk #(
  .COLS(COLS), .TOTAL(COLS + HBLANK), .HS_START(HS_START), .SCANS(SCANS),
  .ROWS(ROWS), .CW(CW), .SW(SW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .col(col), .scan(scan), .row(row),
  .hdrive(hdrive), .vdrive(vdrive)
);

// File: tb/chardisp_timing_test.sv
module chardisp_timing_test;
  localparam int T = 100;
  localparam int LINES = 260;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0;
  logic [6:0] cur_col = '0;
  logic [4:0] cur_row = '0;
  logic [6:0] col;
  logic [3:0] scan;
  logic [4:0] row;
  logic hdrive, vdrive, de;
  logic [10:0] addr;

  int vectors = 0;
  int fails = 0;
  int n = 0;  // posedges since reset release

  always #4 clk = ~clk;

  chardisp_timing uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cur_col(cur_col), .cur_row(cur_row),
    .col(col), .scan(scan), .row(row), .hdrive(hdrive), .vdrive(vdrive),
    .de(de), .addr(addr)
  );

  always @(posedge clk) if (rst_n) n <= n + 1;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 col", int'(col), 0);
    chk("R1 scan", int'(scan), 0);
    chk("R1 row", int'(row), 0);
    chk("R1 hdrive", int'(hdrive), 0);
    chk("R1 vdrive", int'(vdrive), 0);
    rst_n = 1'b1;
  endtask

  // Full frame plus margin, compared every cycle against closed-form counts
  task automatic test_frames(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      begin
        int ln, ecol, escan, erow, ehd, evd, ede, eaddr, ph;
        ecol = n % T;
        ln = ((n + T - 80 - 1) / T) % LINES;
        escan = ln % 10;
        erow = ln / 10;
        ph = (n >= 1) ? (n - 1) % T : -1;
        ehd = (ph >= 84 && ph <= 91) ? 1 : 0;
        evd = (ln >= 240 && ln <= 243) ? 1 : 0;
        ede = (ecol < 80 && erow < 24) ? 1 : 0;
        eaddr = (erow * 80 + ecol) % 2048;
        chk("R2 col", int'(col), ecol);
        chk("R3 scan", int'(scan), escan);
        chk("R3 row", int'(row), erow);
        chk("R4 hdrive", int'(hdrive), ehd);
        chk("R5 vdrive", int'(vdrive), evd);
        chk("R6 de", int'(de), ede);
        chk("R7 addr", int'(addr), eaddr);
      end
    end
  endtask

  task automatic test_cursor();
    int c0, r0;
    @(negedge clk);
    c0 = int'(col); r0 = int'(row);
    src_sel = 1'b1; cur_col = 7'd79; cur_row = 5'd23;
    #1 chk("R8 addr corner", int'(addr), 23 * 80 + 79);
    cur_col = 7'd0; cur_row = 5'd0;
    #1 chk("R8 addr origin", int'(addr), 0);
    cur_col = 7'd17; cur_row = 5'd5;
    #1 chk("R8 addr mid", int'(addr), 5 * 80 + 17);
    @(negedge clk);
    chk("R8 raster unaffected", int'(col), (c0 + 1) % T);
    src_sel = 1'b0;
    #1 chk("R7 addr back", int'(addr), (int'(row) * 80 + int'(col)) % 2048);
    if (r0 < 0) chk("R8 unreachable", 0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_frames(T * LINES + 2 * T + 50);
    test_cursor();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule